// File: doc/BRIEF.md
# Flagless Compare-Capable Integer ALU

This block is the integer arithmetic and logic unit of a 64-bit register machine. It takes two operands and a 4-bit operation code and produces one 64-bit result. It covers full-width addition and subtraction, half-width addition and subtraction with a choice of sign or zero extension of the low half, the three bitwise operations, and six compares. Every compare delivers its truth value as an ordinary register value: 0 or 1.

Subtraction and all compares use one shared adder. For these operations the adder inverts the second operand and sets the carry-in. The compares are decoded from four conditions of that subtraction: zero, carry (meaning "no borrow"), sign and overflow. These conditions exist only inside the cycle in which they are computed. No flag register holds them, and no later operation can see them. Less-than and less-or-equal have no codes of their own. The issuer gets them by swapping the operands of greater-than and greater-or-equal.

The arithmetic is combinational. A single output register stage captures the result whenever the input valid is high. The output valid follows the input valid one cycle later.

Top module: `flagless_alu`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous rising clock edge. While `rst_n` is low at a rising edge, both `out_valid` and `result` become 0 at that edge.
- R2: Code 0 yields `src_a + src_b` modulo 2^DATA_W. Code 1 yields `src_a - src_b` modulo 2^DATA_W.
- R3: Code 2 (half add) and code 3 (half subtract) compute the sum or difference in the low HALF_W bits and copy bit HALF_W-1 of it into all upper bits.
- R4: Code 4 (half add) and code 5 (half subtract) compute the sum or difference in the low HALF_W bits and clear all upper bits.
- R5: Code 6 yields bitwise AND, code 7 bitwise OR and code 8 bitwise XOR of the two operands.
- R6: Code 9 yields 1 when the operands are equal over the full width, else 0. Code 10 yields the inverse.
- R7: Code 11 yields 1 when `src_a` > `src_b` as two's-complement numbers over the full width. Code 12 yields 1 when `src_a` >= `src_b` in the same sense. Otherwise both yield 0.
- R8: Code 13 yields 1 when `src_a` > `src_b` as unsigned numbers. Code 14 yields 1 when `src_a` >= `src_b` as unsigned numbers. Otherwise both yield 0.
- R9: The result of any compare (codes 9 to 14) has every bit except bit 0 cleared.
- R10: The unused code 15 yields a result of 0.
- R11: When `in_valid` is low at a rising edge, `result` keeps its previous value and `out_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and code are present this cycle |
| op | input | 4 | Operation code (0 to 15, see requirements) |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second operand, inverted internally for subtraction and compares |
| out_valid | output | 1 | Registered result is fresh |
| result | output | DATA_W | Registered result |

## Verification
The hardest situation to reach from the ports is a signed compare whose internal subtraction overflows. For the result to be right, the sign and overflow conditions must cancel. This only happens when the operands have opposite signs and lie near the extremes of the range. The same applies to half-width results whose upper bits must be filled from bit HALF_W-1 rather than from the full-width sum. The bench builds the ALU with an 8-bit datapath and a 4-bit half, so that the extremes are close together. It sweeps every first operand against a second operand drawn from the range boundaries plus values equal to, adjacent to and the inverse of the first. This pattern reaches overflow, equality and carry-boundary cases for every operation code.

// File: rtl/flagless_alu_pkg.sv
// Package: shared operation encoding for the flagless ALU.
// Assumes a 4-bit code; code 15 is unused and yields zero.
package flagless_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDSX = 4'd2,
        OP_SUBSX = 4'd3,
        OP_ADDZX = 4'd4,
        OP_SUBZX = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_XOR   = 4'd8,
        OP_EQ    = 4'd9,
        OP_NE    = 4'd10,
        OP_SGT   = 4'd11,
        OP_SGE   = 4'd12,
        OP_UGT   = 4'd13,
        OP_UGE   = 4'd14,
        OP_NONE  = 4'd15
    } alu_op_e;

    // True for the six compare codes.
    function automatic logic op_is_compare(alu_op_e code);
        return (code >= OP_EQ) && (code <= OP_UGE);
    endfunction

    // True for every code that subtracts on the shared adder.
    function automatic logic op_uses_sub(alu_op_e code);
        return (code == OP_SUB) || (code == OP_SUBSX) ||
               (code == OP_SUBZX) || op_is_compare(code);
    endfunction

endpackage

// File: rtl/alu_adder.sv
// Module: alu_adder
// Shared adder for add, subtract and compare. In subtract mode the second
// operand is bit-inverted and the carry-in is set, so carry out means
// "no borrow". Also produces zero, sign and signed-overflow conditions,
// which are meaningful for the full-width sum only.
module alu_adder #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic              sub_mode,
    output logic [DATA_W-1:0] sum,
    output logic              cond_z,
    output logic              cond_c,
    output logic              cond_s,
    output logic              cond_o
);
    localparam int EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] b_eff;
    logic [EXT_W-1:0]  wide_sum;

    // Invert the second operand for subtraction.
    always_comb b_eff = sub_mode ? ~opd_b : opd_b;

    // One adder with a carry-in equal to the subtract mode bit.
    always_comb wide_sum = {1'b0, opd_a} + {1'b0, b_eff} + EXT_W'(sub_mode);

    // Split the sum and carry out.
    always_comb begin
        sum    = wide_sum[DATA_W-1:0];
        cond_c = wide_sum[DATA_W];
    end

    // Zero, sign and overflow of the full-width sum.
    always_comb begin
        cond_z = (sum == '0);
        cond_s = sum[DATA_W-1];
        cond_o = (opd_a[DATA_W-1] == b_eff[DATA_W-1]) &&
                 (sum[DATA_W-1] != opd_a[DATA_W-1]);
    end

endmodule

// File: rtl/alu_bitwise.sv
// Module: alu_bitwise
// Bitwise AND, OR and XOR unit. Assumes the caller selects its output
// only for the three bitwise codes; any other code gives zero here.
module alu_bitwise
    import flagless_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  alu_op_e           code,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    output logic [DATA_W-1:0] bits_out
);
    // Pick the bitwise function by code.
    always_comb begin
        unique case (code)
            OP_AND:  bits_out = opd_a & opd_b;
            OP_OR:   bits_out = opd_a | opd_b;
            OP_XOR:  bits_out = opd_a ^ opd_b;
            default: bits_out = '0;
        endcase
    end

endmodule

// File: rtl/alu_compare.sv
// Module: alu_compare
// Turns the internal conditions of a full-width subtraction a - b into
// the truth value of one compare code. Assumes the adder ran in subtract
// mode. Non-compare codes give 0.
module alu_compare
    import flagless_alu_pkg::*;
(
    input  alu_op_e code,
    input  logic    cond_z,
    input  logic    cond_c,
    input  logic    cond_s,
    input  logic    cond_o,
    output logic    truth
);
    logic sign_ok;

    // Signed a >= b holds exactly when sign and overflow agree.
    always_comb sign_ok = (cond_s == cond_o);

    // Decode the requested relation from the conditions.
    always_comb begin
        unique case (code)
            OP_EQ:   truth = cond_z;
            OP_NE:   truth = ~cond_z;
            OP_SGT:  truth = sign_ok && !cond_z;
            OP_SGE:  truth = sign_ok;
            OP_UGT:  truth = cond_c && !cond_z;
            OP_UGE:  truth = cond_c;
            default: truth = 1'b0;
        endcase
    end

endmodule

// File: rtl/flagless_alu.sv
// Module: flagless_alu (top)
// Two-operand integer ALU with no flag state. Arithmetic and compares
// share one adder. Half-width results are sign- or zero-extended.
// Compares return 0 or 1. A single output register captures the result
// when in_valid is high. out_valid follows in_valid one cycle later.
// Reset is synchronous and active low. Assumes HALF_W < DATA_W.
module flagless_alu
    import flagless_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int UPPER_W = DATA_W - HALF_W;

    alu_op_e           code;
    logic              use_sub;
    logic [DATA_W-1:0] sum;
    logic              cz, cc, cs, co;
    logic [DATA_W-1:0] bits_out;
    logic              truth;
    logic [HALF_W-1:0] half_sum;
    logic [DATA_W-1:0] half_sx;
    logic [DATA_W-1:0] half_zx;
    logic [DATA_W-1:0] next_result;

    // Interpret the raw code and decide on adder mode.
    always_comb begin
        code    = alu_op_e'(op);
        use_sub = op_uses_sub(code);
    end

    alu_adder #(.DATA_W(DATA_W)) u_adder (
        .opd_a    (src_a),
        .opd_b    (src_b),
        .sub_mode (use_sub),
        .sum      (sum),
        .cond_z   (cz),
        .cond_c   (cc),
        .cond_s   (cs),
        .cond_o   (co)
    );

    alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .code     (code),
        .opd_a    (src_a),
        .opd_b    (src_b),
        .bits_out (bits_out)
    );

    alu_compare u_compare (
        .code   (code),
        .cond_z (cz),
        .cond_c (cc),
        .cond_s (cs),
        .cond_o (co),
        .truth  (truth)
    );

    // Build the two half-width extensions of the adder output.
    always_comb begin
        half_sum = sum[HALF_W-1:0];
        half_sx  = {{UPPER_W{half_sum[HALF_W-1]}}, half_sum};
        half_zx  = {{UPPER_W{1'b0}}, half_sum};
    end

    // Select the result by code.
    always_comb begin
        unique case (code)
            OP_ADD, OP_SUB:                   next_result = sum;
            OP_ADDSX, OP_SUBSX:               next_result = half_sx;
            OP_ADDZX, OP_SUBZX:               next_result = half_zx;
            OP_AND, OP_OR, OP_XOR:            next_result = bits_out;
            OP_EQ, OP_NE, OP_SGT, OP_SGE,
            OP_UGT, OP_UGE:                   next_result = DATA_W'(truth);
            default:                          next_result = '0;
        endcase
    end

    // Output register: clear on reset, capture on valid, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_result;
            end
        end
    end

    // R1: valid is delayed by exactly one cycle.
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: the result register holds when no operation is issued.
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R8: the adder carry in subtract mode means the operands do not borrow.
    p_carry_no_borrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        use_sub |-> (cc == (src_a >= src_b)));

    // R6: the zero condition of a subtraction marks equal operands.
    p_zero_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        use_sub |-> (cz == (src_a == src_b)));

    // R7: the signed greater-than decode matches a signed relation.
    p_signed_gt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code == OP_SGT) |-> (truth == ($signed(src_a) > $signed(src_b))));

    // R9: a compare leaves only bit 0 possibly set.
    p_cmp_boolean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_compare(code)) |=> (result[DATA_W-1:1] == '0));

    // R3: sign-extended half results have uniform upper bits.
    p_sext_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (code == OP_ADDSX || code == OP_SUBSX)) |=>
        ((result[DATA_W-1:HALF_W-1] == '0) || (result[DATA_W-1:HALF_W-1] == '1)));

    // R4: zero-extended half results have clear upper bits.
    p_zext_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (code == OP_ADDZX || code == OP_SUBZX)) |=>
        (result[DATA_W-1:HALF_W] == '0));

    // R10: the unused code yields zero.
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code == OP_NONE) |=> (result == '0));

endmodule

// File: tb/flagless_alu_bench.sv
module flagless_alu_bench;
    localparam int W = 8;
    localparam int H = 4;
    localparam int MASK_W = (1 << W) - 1;
    localparam int MASK_H = (1 << H) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [3:0]   op;
    logic [W-1:0] src_a, src_b;
    logic         out_valid;
    logic [W-1:0] result;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic         pend_v;
    logic [W-1:0] pend_r;
    string        pend_tag;
    bit           pend_cmp;

    always #5 clk = ~clk;

    flagless_alu #(.DATA_W(W), .HALF_W(H)) u_flagless_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic int sgn(int v);
        return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
    endfunction

    function automatic logic [W-1:0] model(int code, int a, int b);
        int t;
        case (code)
            0: return W'((a + b) & MASK_W);
            1: return W'((a - b) & MASK_W);
            2, 3: begin
                t = ((code == 2) ? (a + b) : (a - b)) & MASK_H;
                if (t >= (1 << (H - 1))) t = t | (MASK_W & ~MASK_H);
                return W'(t);
            end
            4: return W'((a + b) & MASK_H);
            5: return W'((a - b) & MASK_H);
            6: return W'(a & b);
            7: return W'(a | b);
            8: return W'(a ^ b);
            9: return W'(a == b);
            10: return W'(a != b);
            11: return W'(sgn(a) > sgn(b));
            12: return W'(sgn(a) >= sgn(b));
            13: return W'(a > b);
            14: return W'(a >= b);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(int code);
        case (code)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5: return "R4";
            6, 7, 8: return "R5";
            9, 10: return "R6";
            11, 12: return "R7";
            13, 14: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Check the output of the previous issue, then issue a new one.
    task automatic step(bit v, int code, int a, int b);
        @(negedge clk);
        chk({pend_tag, " valid R1"}, W'(out_valid), W'(pend_v));
        chk(pend_tag, result, pend_r);
        if (pend_cmp) chk("R9", {result[W-1:1], 1'b0}, '0);
        in_valid = v;
        op = 4'(code);
        src_a = W'(a);
        src_b = W'(b);
        pend_v = v;
        pend_cmp = v && (code >= 9) && (code <= 14);
        if (v) begin
            pend_r = model(code, a, b);
            pend_tag = tag_of(code);
        end else begin
            pend_tag = "R11";
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int bset [12] = '{0, 1, 7, 8, 9, 15, 16, 127, 128, 129, 254, 255};
        rst_n = 1'b0;
        in_valid = 1'b1;
        op = 4'd7;
        src_a = 8'hff;
        src_b = 8'hff;
        repeat (3) @(negedge clk);
        // R1: reset clears the outputs even with valid input present.
        chk("R1 reset valid", W'(out_valid), '0);
        chk("R1 reset result", result, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        pend_v = 1'b0;
        pend_r = '0;
        pend_tag = "R1";
        pend_cmp = 1'b0;
        for (int code = 0; code < 16; code++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 16; j++) begin
                    int b;
                    if (j < 12) b = bset[j];
                    else if (j == 12) b = a;
                    else if (j == 13) b = (a + 1) & MASK_W;
                    else if (j == 14) b = (a - 1) & MASK_W;
                    else b = ~a & MASK_W;
                    step(1'b1, code, a, b);
                end
                // R11: idle issue with other operands must not disturb result.
                step(1'b0, (code + 1) % 16, a ^ 8'h5a, a);
            end
        end
        step(1'b0, 0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule